// File: doc/BRIEF.md
# Burst Beat Encoder

The block sits between a bus master's request logic and a 32-bit bus. The master hands it one request at a time: a start address, an access size and a beat count. The block checks the request and, if it is legal, issues one beat per cycle over a valid/ready handshake. Each beat carries four active-low byte-lane enables, a 2-bit size code, a 3-bit sequential-status code and the beat address.

The sequential status describes where a beat sits in its transfer. The opening beat of a long transfer announces the total length. The beats in between say "continuous", which means the next address follows from the current one. The closing beat returns to "single". Requests with an unsupported count, the reserved size or a misaligned address produce a one-cycle error pulse and issue no beats. A new request is taken only after the last beat of the current one has been handed over.

Top module: `burst_beat_encoder`

## Requirements
- R1: While reset is held, `beat_valid` is 0, `beat_ben_n` is 4'b1111, `err_pulse` is 0 and `req_ready` is 1.
- R2: Enable bit k (active low) selects data bits 8k+7:8k. A byte beat drives only lane addr[1:0] low. A halfword beat drives 4'b1100 when addr[1]=0 and 4'b0011 when addr[1]=1. A word beat drives 4'b0000.
- R3: `beat_size` repeats the request size: 00 byte, 01 halfword, 10 word. Code 11 is never driven.
- R4: The first beat of an N-beat transfer with N in {4,8,16,32,64,128} carries the status code log2(N), which gives 010, 011, 100, 101, 110 and 111 in that order.
- R5: Beats after the first and before the last carry 001 (continuous). The last beat carries 000 (single).
- R6: A 2-beat transfer carries 001 and then 000. A 1-beat transfer carries 000 on its only beat.
- R7: A beat count outside {1,2,4,8,16,32,64,128} raises `err_pulse` for exactly one cycle, in the cycle after acceptance. No beat is issued for it.
- R8: A request with size 11, a halfword at an odd address, or a word with addr[1:0] other than 00 raises the same error pulse. No beat is issued for it.
- R9: Each beat's address equals the previous beat's address plus 1, 2 or 4 bytes for byte, halfword or word size. The first beat's address is the request address, and the first beat appears in the cycle after acceptance.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, every beat output holds its value into the next cycle.
- R11: When `beat_valid` is 0, the outputs read `beat_ben_n`=4'b1111, `beat_size`=00, `beat_seq`=000 and `beat_addr`=0.
- R12: `req_ready` is 0 from the cycle after a legal request is accepted until the cycle after its final beat handshake. It is 1 in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Start byte address |
| req_size | input | 2 | Access size code |
| req_beats | input | 8 | Number of beats |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |
| beat_valid | output | 1 | Beat outputs are meaningful |
| beat_ready | input | 1 | Bus takes the current beat |
| beat_ben_n | output | 4 | Active-low byte-lane enables |
| beat_size | output | 2 | Transfer-size code |
| beat_seq | output | 3 | Sequential-status code |
| beat_addr | output | 32 | Beat byte address |

## Verification
Two things can happen in the same cycle: the final-beat handshake that frees the block, and a waiting request from the master. The bench offers a new request while the last beat of a 2-beat transfer is still on the bus. It checks that `req_ready` stays low through that handshake and that the request is taken only in the following cycle. Its first beat must then appear with the right address and status. A stalled burst is also held with `beat_ready` low, and the frozen outputs and the address step after release are compared with values the bench computes itself.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_RSVD = 2'b11;

    localparam logic [2:0] SEQ_SINGLE = 3'b000;
    localparam logic [2:0] SEQ_CONT   = 3'b001;

    // longest announced burst is 2**MAX_LOG beats
    localparam int MAX_LOG = 7;
endpackage

// File: rtl/bbe_align_check.sv
module bbe_align_check
    import bbe_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LSB_W = $clog2(LANES)
) (
    input  logic [LSB_W-1:0] addr_lsb,
    input  logic [1:0]       size,
    output logic             aligned
);
    logic [LSB_W:0]   width;
    logic [LSB_W-1:0] mask;

    always_comb begin
        width   = (LSB_W+1)'(1) << size;
        mask    = LSB_W'(width - 1'b1);
        aligned = (size != SZ_RSVD) && ((addr_lsb & mask) == '0);
    end
endmodule

// File: rtl/bbe_lane_decode.sv
module bbe_lane_decode #(
    parameter int LANES = 4,
    localparam int LSB_W = $clog2(LANES)
) (
    input  logic [LSB_W-1:0] addr_lsb,
    input  logic [1:0]       size,
    output logic [LANES-1:0] ben_n
);
    logic [LSB_W:0] base;
    logic [LSB_W:0] width;

    assign base  = {1'b0, addr_lsb};
    assign width = (LSB_W+1)'(1) << size;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ben_n[g] = !(((LSB_W+1)'(g) >= base) &&
                            ((LSB_W+1)'(g) < (base + width)));
    end
endmodule

// File: rtl/bbe_len_code.sv
module bbe_len_code
    import bbe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] beats,
    output logic [2:0]       code,
    output logic             legal
);
    always_comb begin
        legal = 1'b0;
        code  = SEQ_SINGLE;
        if (beats == CNT_W'(1)) begin
            legal = 1'b1;
            code  = SEQ_SINGLE;
        end else if (beats == CNT_W'(2)) begin
            legal = 1'b1;
            code  = SEQ_CONT;
        end
        for (int k = 2; k <= MAX_LOG; k++) begin
            if (beats == (CNT_W'(1) << k)) begin
                legal = 1'b1;
                code  = 3'(k);
            end
        end
    end
endmodule

// File: rtl/burst_beat_encoder.sv
module burst_beat_encoder
    import bbe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int LANES  = 4,
    localparam int LSB_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [CNT_W-1:0]  req_beats,
    output logic              err_pulse,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [LANES-1:0]  beat_ben_n,
    output logic [1:0]        beat_size,
    output logic [2:0]        beat_seq,
    output logic [ADDR_W-1:0] beat_addr
);
    typedef struct packed {
        logic              busy;
        logic              valid;
        logic              first;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic [CNT_W-1:0]  rem;
        logic [2:0]        first_code;
    } state_t;

    state_t s_d, s_q;

    logic             req_aligned;
    logic             len_legal;
    logic [2:0]       len_code;
    logic [LANES-1:0] lane_ben_n;
    logic             accept_d;
    logic             fire_d;
    logic [2:0]       seq_d;

    bbe_align_check #(.LANES(LANES)) u_align (
        .addr_lsb (req_addr[LSB_W-1:0]),
        .size     (req_size),
        .aligned  (req_aligned)
    );

    bbe_len_code #(.CNT_W(CNT_W)) u_len (
        .beats (req_beats),
        .code  (len_code),
        .legal (len_legal)
    );

    bbe_lane_decode #(.LANES(LANES)) u_lanes (
        .addr_lsb (s_q.addr[LSB_W-1:0]),
        .size     (s_q.size),
        .ben_n    (lane_ben_n)
    );

    always_comb begin
        s_d      = s_q;
        s_d.err  = 1'b0;
        accept_d = req_valid && !s_q.busy;
        fire_d   = s_q.valid && beat_ready;

        if (accept_d) begin
            if (len_legal && req_aligned) begin
                s_d.busy       = 1'b1;
                s_d.valid      = 1'b1;
                s_d.first      = 1'b1;
                s_d.addr       = req_addr;
                s_d.size       = req_size;
                s_d.rem        = req_beats;
                s_d.first_code = len_code;
            end else begin
                s_d.err = 1'b1;
            end
        end

        if (fire_d) begin
            if (s_q.rem == CNT_W'(1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b0;
            end else begin
                s_d.addr  = s_q.addr + (ADDR_W'(1) << s_q.size);
                s_d.rem   = s_q.rem - CNT_W'(1);
                s_d.first = 1'b0;
            end
        end

        if (s_q.first)
            seq_d = s_q.first_code;
        else if (s_q.rem == CNT_W'(1))
            seq_d = SEQ_SINGLE;
        else
            seq_d = SEQ_CONT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = !s_q.busy;
    assign err_pulse  = s_q.err;
    assign beat_valid = s_q.valid;
    assign beat_ben_n = s_q.valid ? lane_ben_n : '1;
    assign beat_size  = s_q.valid ? s_q.size   : SZ_BYTE;
    assign beat_seq   = s_q.valid ? seq_d      : SEQ_SINGLE;
    assign beat_addr  = s_q.valid ? s_q.addr   : '0;

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_size == SZ_BYTE) |-> ($countones(~beat_ben_n) == 1)); // R2
    AST_SIZE_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_size != SZ_RSVD)); // R3
    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !beat_valid); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_seq != SEQ_SINGLE) |=>
        (beat_valid && beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(beat_size)))); // R9
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=>
        (beat_valid && $stable(beat_addr) && $stable(beat_seq) &&
         $stable(beat_ben_n) && $stable(beat_size))); // R10
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_ben_n == '1 && beat_seq == SEQ_SINGLE)); // R11
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready); // R12
endmodule

// File: tb/test_burst_beat_encoder.sv
`timescale 1ns/1ps
module test_burst_beat_encoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [7:0]  req_beats;
    logic        err_pulse;
    logic        beat_valid;
    logic        beat_ready;
    logic [3:0]  beat_ben_n;
    logic [1:0]  beat_size;
    logic [2:0]  beat_seq;
    logic [31:0] beat_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_beat_encoder i_burst_beat_encoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_beats(req_beats),
        .err_pulse(err_pulse),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_ben_n(beat_ben_n), .beat_size(beat_size),
        .beat_seq(beat_seq), .beat_addr(beat_addr)
    );

    // bad: 0 legal, 1 illegal count, 2 misaligned or reserved size
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [7:0]  beats;
        logic [1:0]  bad;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0100, 2'd0, 8'd1,   2'd0},
        '{32'h0000_0103, 2'd0, 8'd2,   2'd0},
        '{32'h0000_0202, 2'd1, 8'd4,   2'd0},
        '{32'h0000_0300, 2'd2, 8'd8,   2'd0},
        '{32'h0000_0001, 2'd0, 8'd16,  2'd0},
        '{32'h0000_0010, 2'd1, 8'd32,  2'd0},
        '{32'h0000_1000, 2'd2, 8'd64,  2'd0},
        '{32'h0000_0007, 2'd0, 8'd128, 2'd0},
        '{32'h0000_0002, 2'd2, 8'd1,   2'd2},
        '{32'h0000_0001, 2'd1, 8'd2,   2'd2},
        '{32'h0000_0000, 2'd3, 8'd4,   2'd2},
        '{32'h0000_0000, 2'd0, 8'd3,   2'd1},
        '{32'h0000_0000, 2'd2, 8'd0,   2'd1},
        '{32'h0000_0000, 2'd1, 8'd5,   2'd1},
        '{32'h0000_0000, 2'd0, 8'd130, 2'd1},
        '{32'h0000_0000, 2'd2, 8'd255, 2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ben(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return ~(4'b0001 << a[1:0]);
            2'd1:    return a[1] ? 4'b0011 : 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [2:0] exp_seq(input int n, input int i);
        if (i == n - 1) return 3'b000;
        if (i == 0) return (n == 2) ? 3'b001 : 3'($clog2(n));
        return 3'b001;
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " R11 valid"}, 32'(beat_valid), 32'd0);
        chk({tag, " R11 ben"},   32'(beat_ben_n), 32'hF);
        chk({tag, " R11 size"},  32'(beat_size),  32'd0);
        chk({tag, " R11 seq"},   32'(beat_seq),   32'd0);
        chk({tag, " R11 addr"},  beat_addr,       32'd0);
        chk({tag, " R12 ready"}, 32'(req_ready),  32'd1);
    endtask

    task automatic check_beat(input logic [31:0] base, input logic [1:0] sz,
                              input int n, input int i);
        logic [31:0] a;
        a = base + (32'(i) << sz);
        chk($sformatf("R9 valid beat %0d/%0d", i, n), 32'(beat_valid), 32'd1);
        chk($sformatf("R9 addr beat %0d/%0d", i, n), beat_addr, a);
        chk($sformatf("R2 ben beat %0d/%0d", i, n), 32'(beat_ben_n), 32'(exp_ben(a, sz)));
        chk($sformatf("R3 size beat %0d/%0d", i, n), 32'(beat_size), 32'(sz));
        if (n <= 2)
            chk($sformatf("R6 seq beat %0d/%0d", i, n), 32'(beat_seq), 32'(exp_seq(n, i)));
        else if (i == 0)
            chk($sformatf("R4 seq beat %0d/%0d", i, n), 32'(beat_seq), 32'(exp_seq(n, i)));
        else
            chk($sformatf("R5 seq beat %0d/%0d", i, n), 32'(beat_seq), 32'(exp_seq(n, i)));
        chk($sformatf("R12 ready beat %0d/%0d", i, n), 32'(req_ready), 32'd0);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_beats = v.beats;
        beat_ready = 1'b1;
        chk("R12 ready before request", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.bad != 2'd0) begin
            if (v.bad == 2'd1) begin
                chk("R7 err pulse", 32'(err_pulse), 32'd1);
                chk("R7 no beat",   32'(beat_valid), 32'd0);
            end else begin
                chk("R8 err pulse", 32'(err_pulse), 32'd1);
                chk("R8 no beat",   32'(beat_valid), 32'd0);
            end
            @(negedge clk);
            chk("R7 pulse width", 32'(err_pulse), 32'd0);
            check_idle("after reject");
        end else begin
            chk("R7 no err on legal", 32'(err_pulse), 32'd0);
            for (int i = 0; i < int'(v.beats); i++) begin
                check_beat(v.addr, v.size, int'(v.beats), i);
                @(negedge clk);
            end
            check_idle("after burst");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a0;
        logic [3:0]  b0;
        logic [2:0]  q0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_beats = '0; beat_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(beat_valid), 32'd0);
        chk("R1 reset ben",   32'(beat_ben_n), 32'hF);
        chk("R1 reset err",   32'(err_pulse),  32'd0);
        chk("R1 reset ready", 32'(req_ready),  32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("post reset");

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // stall: word, 4 beats, bus not ready for two cycles
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h40; req_size = 2'd2; req_beats = 8'd4;
        beat_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        a0 = beat_addr; b0 = beat_ben_n; q0 = beat_seq;
        chk("R4 stall first seq", 32'(q0), 32'h2);
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            chk("R10 held valid", 32'(beat_valid), 32'd1);
            chk("R10 held addr",  beat_addr, a0);
            chk("R10 held ben",   32'(beat_ben_n), 32'(b0));
            chk("R10 held seq",   32'(beat_seq), 32'(q0));
        end
        beat_ready = 1'b1;
        @(negedge clk);
        chk("R9 after stall addr", beat_addr, 32'h44);
        chk("R5 after stall seq",  32'(beat_seq), 32'h1);
        repeat (3) @(negedge clk);
        check_idle("after stall");

        // new request waiting while the last beat completes
        req_valid = 1'b1; req_addr = 32'h50; req_size = 2'd0; req_beats = 8'd2;
        @(negedge clk);
        req_addr = 32'h60; req_size = 2'd2; req_beats = 8'd1;
        chk("R6 two-beat first", 32'(beat_seq), 32'h1);
        @(negedge clk);
        chk("R6 two-beat last", 32'(beat_seq), 32'h0);
        chk("R12 busy on last beat", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R12 free after last", 32'(req_ready), 32'd1);
        chk("R12 no beat yet", 32'(beat_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 queued start addr", beat_addr, 32'h60);
        chk("R6 queued single seq", 32'(beat_seq), 32'h0);
        chk("R2 queued word ben", 32'(beat_ben_n), 32'h0);
        @(negedge clk);
        check_idle("after queued");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule